// File: doc/BRIEF.md
# Zero-Lag Cross-Correlator Array

This block correlates a bank of receiver sample bits pair by pair at zero delay. On every clock it forms the product of each distinct pair of channels sampled in that cycle. It adds each product into a signed counter that belongs to that baseline. It also keeps one occupancy counter per channel and a counter of integrated clock cycles.

A mode input selects how the sample bits are read. In two-level mode each bit is one channel worth plus or minus one. In three-level mode adjacent bits are paired into sign/magnitude channels, which halves the channel count. A dump strobe ends an integration. The totals, including the sample taken in the dump cycle, are copied to held outputs, and every counter starts the next integration from zero on the following cycle.

Top module: `xcorr_array`

## Requirements
- R1: In two-level mode (mode_i = 0) sample bit k is channel k, with 1 meaning +1 and 0 meaning -1. Each cycle, the pair counter of channels i and j gains +1 when their bits are equal and -1 when they differ.
- R2: There are NUM_IN*(NUM_IN-1)/2 pair slots, ordered row-major over i<j: (0,1), (0,2), ..., (0,N-1), (1,2), and so on. Slot p occupies bits [p*CNT_W +: CNT_W] of pair_cnt_o as a two's-complement count.
- R3: In three-level mode (mode_i = 1), channel k takes its sign from bit 2k (1 means negative) and its magnitude from bit 2k+1 (1 means nonzero). The product is 0 when either magnitude is 0. Otherwise it is +1 for equal signs and -1 for unequal signs. The NUM_IN/2 channels fill the first (N/2)(N/2-1)/2 slots in the same row-major order.
- R4: In three-level mode, pair slots past the channel-pair count and monitors NUM_IN/2 and above receive no contribution. After an integration spent wholly in that mode they report zero.
- R5: Monitor k (bits [k*CNT_W +: CNT_W] of mon_cnt_o) counts the cycles in which channel k was +1 in two-level mode, or nonzero in three-level mode.
- R6: cyc_cnt_o reports the number of clock cycles in the integration, counting the dump cycle.
- R7: When dump_i is high at a clock edge, the held outputs take the totals including that edge's sample, visible from the next cycle. Counting restarts from zero, so back-to-back dumps each report exactly one cycle.
- R8: The held outputs do not change on edges where dump_i is low.
- R9: A low rst_n at a clock edge clears every counter and every held output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 0: two-level, 1: three-level |
| dump_i | input | 1 | End of integration strobe |
| samp_i | input | NUM_IN | Sample bits, one per input line |
| pair_cnt_o | output | NUM_PAIRS*CNT_W | Held baseline counts, row-major |
| mon_cnt_o | output | NUM_IN*CNT_W | Held per-channel monitor counts |
| cyc_cnt_o | output | CNT_W | Held integration length in cycles |

## Verification
The dump strobe and the accumulation of that cycle's sample fall on the same edge. The risk is that the sample is dropped, or that it is counted both in the closing and in the next integration. The bench drives contiguous integrations whose last sample coincides with the dump and compares every slot against a bench-side model of the exact cycle count. It also issues dumps on consecutive cycles, where each capture must hold exactly one sample and a cycle count of one.

// File: rtl/xcorr_pkg.sv
// Shared encoding and helpers for the correlator array.
// Channel values use a 2-bit code: 01 = +1, 11 = -1, 00 = 0.
package xcorr_pkg;

    localparam logic [1:0] TERN_POS  = 2'b01;
    localparam logic [1:0] TERN_NEG  = 2'b11;
    localparam logic [1:0] TERN_ZERO = 2'b00;

    // Product of two coded values; any zero operand yields zero.
    function automatic logic [1:0] tern_mul(input logic [1:0] a, input logic [1:0] b);
        if (a == TERN_ZERO || b == TERN_ZERO) begin
            return TERN_ZERO;
        end
        return (a[1] ^ b[1]) ? TERN_NEG : TERN_POS;
    endfunction

    // Row index of row-major pair slot p among n channels.
    function automatic int pair_row(input int p, input int n);
        int k;
        k = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = i + 1; j < n; j++) begin
                if (k == p) return i;
                k++;
            end
        end
        return 0;
    endfunction

    // Column index of row-major pair slot p among n channels.
    function automatic int pair_col(input int p, input int n);
        int k;
        k = 0;
        for (int i = 0; i < n; i++) begin
            for (int j = i + 1; j < n; j++) begin
                if (k == p) return j;
                k++;
            end
        end
        return 1;
    endfunction

endpackage

// File: rtl/xcorr_chan_decode.sv
// Turns raw sample bits into per-channel coded values and monitor increments.
// Assumes NUM_IN is even. Channels at or above NUM_IN/2 are silent in
// three-level mode.
module xcorr_chan_decode
    import xcorr_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic                    mode_i,
    input  logic [NUM_IN-1:0]       samp_i,
    output logic [NUM_IN-1:0][1:0]  val_o,
    output logic [NUM_IN-1:0]       inc_o
);

    localparam int HALF = NUM_IN / 2;

    for (genvar k = 0; k < NUM_IN; k++) begin : g_chan
        if (k < HALF) begin : g_dual
            // Decode channel k for whichever mode is active.
            always_comb begin
                if (mode_i) begin
                    if (!samp_i[2*k+1])  val_o[k] = TERN_ZERO;
                    else if (samp_i[2*k]) val_o[k] = TERN_NEG;
                    else                  val_o[k] = TERN_POS;
                    inc_o[k] = samp_i[2*k+1];
                end else begin
                    val_o[k] = samp_i[k] ? TERN_POS : TERN_NEG;
                    inc_o[k] = samp_i[k];
                end
            end
        end else begin : g_upper
            // Upper channels exist only in two-level mode.
            always_comb begin
                if (mode_i) begin
                    val_o[k] = TERN_ZERO;
                    inc_o[k] = 1'b0;
                end else begin
                    val_o[k] = samp_i[k] ? TERN_POS : TERN_NEG;
                    inc_o[k] = samp_i[k];
                end
            end
        end
    end

endmodule

// File: rtl/xcorr_accum.sv
// One integrating counter with a held copy. On dump, the held copy takes
// the running total plus the current step, and the total restarts at zero.
// The step is a 2-bit two's-complement value (-1, 0, +1).
module xcorr_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dump_i,
    input  logic [1:0]       step_i,
    output logic [CNT_W-1:0] held_o
);

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] step_ext;
    logic [CNT_W-1:0] sum;

    // Sign-extend the step and form the next total.
    always_comb begin
        step_ext = {{(CNT_W-2){step_i[1]}}, step_i};
        sum      = acc_q + step_ext;
    end

    // Integrate, or capture and restart on dump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            held_o <= '0;
        end else if (dump_i) begin
            acc_q  <= '0;
            held_o <= sum;
        end else begin
            acc_q  <= sum;
        end
    end

    p_hold_between_dumps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dump_i |=> $stable(held_o));

    p_restart_after_dump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dump_i |=> acc_q == '0);

endmodule

// File: rtl/xcorr_array.sv
// Zero-lag cross-correlator over NUM_IN sample lines. Every distinct channel
// pair is multiplied each cycle and integrated into its own counter. Also
// integrated are per-channel monitors and a cycle counter. Assumes NUM_IN is
// even, mode_i is held steady within an integration, and CNT_W is wide
// enough for the longest integration.
module xcorr_array
    import xcorr_pkg::*;
#(
    parameter int NUM_IN    = 8,
    parameter int CNT_W     = 16,
    parameter int NUM_PAIRS = NUM_IN * (NUM_IN - 1) / 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_i,
    input  logic                         dump_i,
    input  logic [NUM_IN-1:0]            samp_i,
    output logic [NUM_PAIRS*CNT_W-1:0]   pair_cnt_o,
    output logic [NUM_IN*CNT_W-1:0]      mon_cnt_o,
    output logic [CNT_W-1:0]             cyc_cnt_o
);

    localparam int HALF     = NUM_IN / 2;
    localparam int HALF_PRS = HALF * (HALF - 1) / 2;

    logic [NUM_IN-1:0][1:0] val;
    logic [NUM_IN-1:0]      mon_inc;

    xcorr_chan_decode #(.NUM_IN(NUM_IN)) u_decode (
        .mode_i (mode_i),
        .samp_i (samp_i),
        .val_o  (val),
        .inc_o  (mon_inc)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int I2 = pair_row(p, NUM_IN);
        localparam int J2 = pair_col(p, NUM_IN);
        logic [1:0] op_a;
        logic [1:0] op_b;
        logic [1:0] prod;

        if (p < HALF_PRS) begin : g_shared
            localparam int I3 = pair_row(p, HALF);
            localparam int J3 = pair_col(p, HALF);
            // Select the operand pair that this slot holds in the active mode.
            always_comb begin
                op_a = mode_i ? val[I3] : val[I2];
                op_b = mode_i ? val[J3] : val[J2];
            end
        end else begin : g_wide_only
            // Slot is used only in two-level mode.
            always_comb begin
                op_a = mode_i ? TERN_ZERO : val[I2];
                op_b = mode_i ? TERN_ZERO : val[J2];
            end
        end

        // Multiply the two coded channel values.
        always_comb prod = tern_mul(op_a, op_b);

        xcorr_accum #(.CNT_W(CNT_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .dump_i (dump_i),
            .step_i (prod),
            .held_o (pair_cnt_o[p*CNT_W +: CNT_W])
        );

        p_zero_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a == TERN_ZERO || op_b == TERN_ZERO) |-> prod == TERN_ZERO);

        p_unit_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_i |-> (prod == TERN_POS || prod == TERN_NEG));
    end

    for (genvar k = 0; k < NUM_IN; k++) begin : g_mon
        xcorr_accum #(.CNT_W(CNT_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .dump_i (dump_i),
            .step_i ({1'b0, mon_inc[k]}),
            .held_o (mon_cnt_o[k*CNT_W +: CNT_W])
        );
    end

    xcorr_accum #(.CNT_W(CNT_W)) u_cycles (
        .clk    (clk),
        .rst_n  (rst_n),
        .dump_i (dump_i),
        .step_i (2'b01),
        .held_o (cyc_cnt_o)
    );

    p_upper_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> mon_inc[NUM_IN-1:HALF] == '0);

    p_cycle_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dump_i |=> cyc_cnt_o != '0);

endmodule

// File: tb/xcorr_array_tb_top.sv
module xcorr_array_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int NP = N * (N - 1) / 2;
    localparam int NT = 6;

    // Stimulus table: mode, sample byte, length; expected slot 0 and monitor 0.
    localparam int T_MODE [NT] = '{0, 0, 0, 1, 1, 1};
    localparam int T_DATA [NT] = '{8'hFF, 8'h00, 8'h01, 8'h0A, 8'h0E, 8'h08};
    localparam int T_LEN  [NT] = '{5, 3, 4, 6, 2, 3};
    localparam int T_P0   [NT] = '{5, 3, -4, 6, -2, 0};
    localparam int T_M0   [NT] = '{5, 0, 4, 6, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic dump = 1'b0;
    logic [N-1:0] samp = '0;
    logic [NP*W-1:0] pair_cnt;
    logic [N*W-1:0]  mon_cnt;
    logic [W-1:0]    cyc_cnt;

    int checks = 0;
    int errors = 0;
    int exp_pair [NP];
    int exp_mon  [N];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcorr_array #(.NUM_IN(N), .CNT_W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .dump_i     (dump),
        .samp_i     (samp),
        .pair_cnt_o (pair_cnt),
        .mon_cnt_o  (mon_cnt),
        .cyc_cnt_o  (cyc_cnt)
    );

    function automatic int pair_at(int p);
        return int'($signed(pair_cnt[p*W +: W]));
    endfunction

    function automatic int mon_at(int k);
        return int'(mon_cnt[k*W +: W]);
    endfunction

    function automatic int chan_val(int m, logic [N-1:0] d, int k);
        if (m == 0) return d[k] ? 1 : -1;
        if (!d[2*k+1]) return 0;
        return d[2*k] ? -1 : 1;
    endfunction

    // Bench model of one integration of a constant sample.
    task automatic model(int m, logic [N-1:0] d, int len);
        int chans;
        int s;
        chans = (m == 0) ? N : N / 2;
        for (int p = 0; p < NP; p++) exp_pair[p] = 0;
        for (int k = 0; k < N; k++) exp_mon[k] = 0;
        s = 0;
        for (int i = 0; i < chans; i++) begin
            for (int j = i + 1; j < chans; j++) begin
                exp_pair[s] = len * chan_val(m, d, i) * chan_val(m, d, j);
                s++;
            end
            exp_mon[i] = (chan_val(m, d, i) == ((m == 0) ? 1 : 0)) ? ((m == 0) ? len : 0) : ((m == 0) ? 0 : len);
        end
    endtask

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_all(string req);
        int bad;
        bad = 0;
        for (int p = 0; p < NP; p++) begin
            if (pair_at(p) != exp_pair[p]) begin
                if (bad == 0) $display("FAIL %s slot %0d actual %0d expected %0d", req, p, pair_at(p), exp_pair[p]);
                bad++;
            end
        end
        for (int k = 0; k < N; k++) begin
            if (mon_at(k) != exp_mon[k]) begin
                if (bad == 0) $display("FAIL %s monitor %0d actual %0d expected %0d", req, k, mon_at(k), exp_mon[k]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    // Hold a sample for len cycles, the last of which carries the dump.
    task automatic integrate(int m, logic [N-1:0] d, int len);
        mode = m[0];
        samp = d;
        dump = 1'b0;
        repeat (len - 1) @(negedge clk);
        dump = 1'b1;
        @(negedge clk);
        dump = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        model(0, '0, 0);
        check_all("R9 reset pairs/monitors");
        check("R9 reset cycles", int'(cyc_cnt), 0);

        integrate(0, '0, 1);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int t = 0; t < NT; t++) begin
            integrate(T_MODE[t], T_DATA[t][N-1:0], T_LEN[t]);
            check("R2 slot0", pair_at(0), T_P0[t]);
            check("R5 mon0", mon_at(0), T_M0[t]);
            check("R6 cycles", int'(cyc_cnt), T_LEN[t]);
            model(T_MODE[t], T_DATA[t][N-1:0], T_LEN[t]);
            check_all(T_MODE[t] == 0 ? "R1 full compare" : "R3 full compare");
        end

        // R4: all channels -1 in three-level mode; upper slots/monitors stay zero
        integrate(1, 8'hFF, 3);
        model(1, 8'hFF, 3);
        check_all("R4 full compare");
        check("R4 first unused slot", pair_at(N/2*(N/2-1)/2), 0);
        check("R4 upper monitor", mon_at(N/2), 0);
        check("R3 slot0 neg*neg", pair_at(0), 3);

        // R8: outputs hold while integrating without a dump
        mode = 1'b0;
        samp = 8'h5A;
        repeat (3) @(negedge clk);
        check_all("R8 held pairs/monitors");
        check("R8 held cycles", int'(cyc_cnt), 3);
        dump = 1'b1;
        @(negedge clk);
        dump = 1'b0;
        model(0, 8'h5A, 4);
        check_all("R7 dump includes hold-time samples");
        check("R6 cycles after hold", int'(cyc_cnt), 4);

        // R7: back-to-back dumps each capture exactly one sample
        integrate(0, 8'hFF, 1);
        check("R7 first single dump cycles", int'(cyc_cnt), 1);
        integrate(0, 8'h0F, 1);
        check("R7 second single dump cycles", int'(cyc_cnt), 1);
        model(0, 8'h0F, 1);
        check_all("R7 second single dump values");

        // R9: reset mid-integration discards partial totals
        samp = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model(0, '0, 0);
        check_all("R9 mid reset cleared");
        check("R9 mid reset cycles", int'(cyc_cnt), 0);
        integrate(0, 8'hFF, 2);
        check("R9 restart cycles", int'(cyc_cnt), 2);
        check("R1 restart slot0", pair_at(0), 2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule